// File: doc/BRIEF.md
# Byte-Serial CRC-16/CRC-32 Register Engine

This block is a small CRC accelerator that sits on a byte-wide special-function-register bus. Software picks CRC-16 or CRC-32 with one control bit and clears the accumulator. It then writes message bytes, one at a time, to the lowest result address. Each accepted byte is folded into a 32-bit accumulator one bit per clock, least significant bit first. A byte therefore takes eight clocks to settle, and software sees that time as a busy flag. The running CRC is read back from the result addresses as two bytes in CRC-16 mode or four bytes in CRC-32 mode.

A write of any value to the second result address clears the whole accumulator, and this is the only way to reset it between messages. The engine applies no initial value and no final inversion, so software adds these if its protocol needs them.

The register interface has no back-pressure. The busy flag acts as the ready indication. A byte written while the engine is still busy is dropped rather than stalled, and the drop is recorded in a sticky overrun flag.

Top module: `crc_sfr_engine`

## Requirements
- R1: After reset, all four result bytes read 0x00, the control/status byte reads 0x00, and the mode is CRC-16.
- R2: Address 4 is control/status. Bit 0 is the mode, read/write, with 0 for CRC-16 and 1 for CRC-32. Bit 1 is busy and is read-only. Bit 2 is overrun and is read-only. Bits 7:3 read 0. A write to address 4 loads the mode and clears overrun.
- R3: In CRC-16 mode, a byte written to address 0 is folded LSB-first into accumulator bits 15:0 with the reflected form of polynomial 0x8005 (0xA001). The result reads as {address 1, address 0}.
- R4: In CRC-32 mode, a byte written to address 0 is folded LSB-first into all 32 bits with the reflected polynomial 0xEDB88320 and no final XOR. Addresses 0..3 hold result bytes from low to high.
- R5: An accepted byte keeps busy high for exactly 8 clocks, one per bit. When busy drops, the result is final.
- R6: A write of any value to address 1 sets all 32 accumulator bits to zero. It also aborts any byte in flight and drops busy.
- R7: A write to address 0 while busy is ignored and leaves the accumulator unchanged. It sets overrun, which stays set until address 4 is written.
- R8: The mode is sampled when a byte is accepted. A mode change while busy applies only to later bytes.
- R9: Writes to addresses 2, 3, 5, 6 and 7 change nothing that can be read.
- R10: The busy_o pin always equals status bit 1.
- R11: In CRC-16 mode, accumulator bits 31:16 (addresses 2 and 3) keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register address for writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| busy_o | output | 1 | High while a byte is being folded in |

## Verification
The hardest situations to reach are those where a second command lands inside the eight-clock window of a byte in flight. These are a data write that must be dropped, a mode change that must not affect the current byte, and a clear that must abort it. The driver places these writes two cycles after an accepted byte, well inside the busy window. The scoreboard holds expected values from a bit-serial reference model that advanced only on the bytes that should have been accepted. Mixed-mode sequences check that CRC-16 work leaves the upper bytes from earlier CRC-32 work untouched.

// File: rtl/crc_sfr_pkg.sv
package crc_sfr_pkg;

  localparam int unsigned SFR_ADDR_W = 3;

  typedef enum logic {
    MODE_C16 = 1'b0,
    MODE_C32 = 1'b1
  } crc_mode_e;

  localparam logic [SFR_ADDR_W-1:0] ADR_RES0 = 3'd0;
  localparam logic [SFR_ADDR_W-1:0] ADR_RES1 = 3'd1;
  localparam logic [SFR_ADDR_W-1:0] ADR_CTRL = 3'd4;

  localparam int unsigned STAT_MODE_BIT = 0;
  localparam int unsigned STAT_BUSY_BIT = 1;
  localparam int unsigned STAT_OVR_BIT  = 2;

  typedef struct packed {
    logic feed;
    logic clear;
    logic ctrl_wr;
  } sfr_cmd_t;

endpackage

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
  parameter int unsigned     W    = 16,
  parameter logic [W-1:0]    POLY = 16'hA001
) (
  input  logic [W-1:0] state_i,
  input  logic         bit_i,
  output logic [W-1:0] state_o
);

  logic fb;

  always_comb begin
    fb      = state_i[0] ^ bit_i;
    state_o = (state_i >> 1) ^ (fb ? POLY : '0);
  end

endmodule

// File: rtl/crc_sfr_regs.sv
module crc_sfr_regs
  import crc_sfr_pkg::*;
#(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SFR_ADDR_W-1:0] addr,
  input  logic                  mode_wbit,
  input  logic [ACC_W-1:0]      acc,
  input  logic                  busy,
  input  logic                  ovr,
  output logic [BYTE_W-1:0]     rdata,
  output sfr_cmd_t              cmd,
  output crc_mode_e             mode
);

  localparam int unsigned NUM_RES = ACC_W / BYTE_W;

  logic [BYTE_W-1:0] res_byte [NUM_RES];

  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    assign res_byte[g] = acc[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    cmd         = '0;
    cmd.feed    = we && (addr == ADR_RES0);
    cmd.clear   = we && (addr == ADR_RES1);
    cmd.ctrl_wr = we && (addr == ADR_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode <= MODE_C16;
    else if (cmd.ctrl_wr) mode <= crc_mode_e'(mode_wbit);
  end

  always_comb begin
    rdata = '0;
    if (addr == ADR_CTRL) begin
      rdata[STAT_MODE_BIT] = mode;
      rdata[STAT_BUSY_BIT] = busy;
      rdata[STAT_OVR_BIT]  = ovr;
    end else if (32'(addr) < NUM_RES) begin
      rdata = res_byte[addr];
    end
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.ctrl_wr |=> (mode == crc_mode_e'($past(mode_wbit)))); // R2

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.ctrl_wr |=> $stable(mode)); // R9

endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
  import crc_sfr_pkg::*;
#(
  parameter int unsigned      ACC_W    = 32,
  parameter int unsigned      NARROW_W = 16,
  parameter int unsigned      BYTE_W   = 8,
  parameter logic [NARROW_W-1:0] POLY_N = 16'hA001,
  parameter logic [ACC_W-1:0]    POLY_W = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feed,
  input  logic [BYTE_W-1:0] feed_byte,
  input  logic              clear,
  input  logic              ovr_clr,
  input  crc_mode_e         mode_sel,
  output logic [ACC_W-1:0]  acc,
  output logic              busy,
  output logic              ovr
);

  localparam int unsigned CNT_W = $clog2(BYTE_W) + 1;

  logic [BYTE_W-1:0]   shreg;
  logic [CNT_W-1:0]    bits_left;
  crc_mode_e           op_mode;
  logic                start;
  logic [NARROW_W-1:0] step_n;
  logic [ACC_W-1:0]    step_w;
  logic [ACC_W-1:0]    acc_next;

  assign start = feed && !busy && !clear;

  crc_bit_step #(.W(NARROW_W), .POLY(POLY_N)) i_step_n (
    .state_i (acc[NARROW_W-1:0]),
    .bit_i   (shreg[0]),
    .state_o (step_n)
  );

  crc_bit_step #(.W(ACC_W), .POLY(POLY_W)) i_step_w (
    .state_i (acc),
    .bit_i   (shreg[0]),
    .state_o (step_w)
  );

  always_comb begin
    if (op_mode == MODE_C32) acc_next = step_w;
    else                     acc_next = {acc[ACC_W-1:NARROW_W], step_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      shreg     <= '0;
      bits_left <= '0;
      busy      <= 1'b0;
      op_mode   <= MODE_C16;
    end else if (clear) begin
      acc       <= '0;
      bits_left <= '0;
      busy      <= 1'b0;
    end else if (start) begin
      shreg     <= feed_byte;
      bits_left <= CNT_W'(BYTE_W);
      busy      <= 1'b1;
      op_mode   <= mode_sel;
    end else if (busy) begin
      acc       <= acc_next;
      shreg     <= shreg >> 1;
      bits_left <= bits_left - CNT_W'(1);
      if (bits_left == CNT_W'(1)) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ovr <= 1'b0;
    else if (ovr_clr)       ovr <= 1'b0;
    else if (feed && busy)  ovr <= 1'b1;
  end

  AST_BYTE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(clear)) |-> ($past(busy, 8) && !$past(busy, 9))); // R5

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clear) |=> $stable(op_mode)); // R8

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_mode == MODE_C16 && !clear) |=> $stable(acc[ACC_W-1:NARROW_W])); // R11

  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (feed && busy && !ovr_clr) |=> ovr); // R7

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr); // R7

endmodule

// File: rtl/crc_sfr_engine.sv
module crc_sfr_engine
  import crc_sfr_pkg::*;
#(
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned BYTE_W   = 8,
  parameter logic [NARROW_W-1:0] POLY_N = 16'hA001,
  parameter logic [ACC_W-1:0]    POLY_W = 32'hEDB88320
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [SFR_ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0]     bus_wdata,
  output logic [BYTE_W-1:0]     bus_rdata,
  output logic                  busy_o
);

  sfr_cmd_t         cmd;
  crc_mode_e        mode;
  logic [ACC_W-1:0] acc;
  logic             busy;
  logic             ovr;

  crc_sfr_regs #(.ACC_W(ACC_W), .BYTE_W(BYTE_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (bus_we),
    .addr      (bus_addr),
    .mode_wbit (bus_wdata[STAT_MODE_BIT]),
    .acc       (acc),
    .busy      (busy),
    .ovr       (ovr),
    .rdata     (bus_rdata),
    .cmd       (cmd),
    .mode      (mode)
  );

  crc_byte_engine #(
    .ACC_W(ACC_W), .NARROW_W(NARROW_W), .BYTE_W(BYTE_W),
    .POLY_N(POLY_N), .POLY_W(POLY_W)
  ) i_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .feed      (cmd.feed),
    .feed_byte (bus_wdata),
    .clear     (cmd.clear),
    .ovr_clr   (cmd.ctrl_wr),
    .mode_sel  (mode),
    .acc       (acc),
    .busy      (busy),
    .ovr       (ovr)
  );

  assign busy_o = busy;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clear |=> (acc == '0 && !busy)); // R6

  AST_FEED_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.feed && !busy) |=> busy); // R5

endmodule

// File: tb/test_crc_sfr_engine.sv
`timescale 1ns/1ps
module test_crc_sfr_engine;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       busy_o;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  logic      mon_req = 1'b0;

  logic [31:0] model = 32'd0;

  always #4 clk = ~clk;

  crc_sfr_engine i_crc_sfr_engine (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_o(busy_o)
  );

  function automatic logic [31:0] ref_byte(input logic [31:0] a, input logic [7:0] b, input bit m32);
    logic [15:0] lo;
    logic fb;
    for (int i = 0; i < 8; i++) begin
      if (m32) begin
        fb = a[0] ^ b[i];
        a  = (a >> 1) ^ (fb ? 32'hEDB88320 : 32'd0);
      end else begin
        lo = a[15:0];
        fb = lo[0] ^ b[i];
        lo = (lo >> 1) ^ (fb ? 16'hA001 : 16'd0);
        a[15:0] = lo;
      end
    end
    return a;
  endfunction

  // monitor: pops the expected item and compares it with the read data
  always @(negedge clk) begin
    if (mon_req && sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        failures++;
        $display("FAIL %s: actual=%02h expected=%02h", it.tag, bus_rdata, it.exp);
      end
      checks++;
      if (busy_o !== ((bus_addr == 3'd4) ? bus_rdata[1] : busy_o)) begin
        failures++;
        $display("FAIL R10: busy_o actual=%0b expected=%0b", busy_o, bus_rdata[1]);
      end
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    mon_req = 1'b1;
    @(posedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic settle();
    repeat (9) @(posedge clk);
  endtask

  task automatic feed(input logic [7:0] d, input bit m32);
    bus_wr(3'd0, d);
    model = ref_byte(model, d, m32);
    settle();
  endtask

  task automatic expect_acc(input string tag);
    expect_rd(3'd0, model[7:0],   tag);
    expect_rd(3'd1, model[15:8],  tag);
    expect_rd(3'd2, model[23:16], tag);
    expect_rd(3'd3, model[31:24], tag);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    logic [7:0] msg [9];
    msg = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_acc("R1 reset result");
    expect_rd(3'd4, 8'h00, "R1 reset status");

    // R3 CRC-16 of ASCII 1..9
    for (int i = 0; i < 9; i++) feed(msg[i], 1'b0);
    expect_rd(3'd0, 8'h3D, "R3 crc16 low");
    expect_rd(3'd1, 8'hBB, "R3 crc16 high");

    // R6 clear with arbitrary data value
    bus_wr(3'd1, 8'hA5);
    model = 32'd0;
    expect_acc("R6 clear");

    // R2 mode write and readback; R4 CRC-32 stream
    bus_wr(3'd4, 8'hFF);
    expect_rd(3'd4, 8'h01, "R2 mode readback");
    for (int i = 0; i < 9; i++) feed(msg[i], 1'b1);
    feed(8'h00, 1'b1);
    feed(8'hFF, 1'b1);
    expect_acc("R4 crc32");

    // R5 busy visible during byte, gone after 8 clocks
    bus_wr(3'd0, 8'h5A);
    model = ref_byte(model, 8'h5A, 1'b1);
    expect_rd(3'd4, 8'h03, "R5 busy during byte");
    settle();
    expect_rd(3'd4, 8'h01, "R5 idle after byte");
    expect_acc("R5 result");

    // R7 write during busy is dropped, overrun sticky
    bus_wr(3'd0, 8'h11);
    model = ref_byte(model, 8'h11, 1'b1);
    bus_wr(3'd0, 8'h77);
    settle();
    expect_acc("R7 dropped byte");
    expect_rd(3'd4, 8'h05, "R7 overrun set");
    feed(8'h22, 1'b1);
    expect_rd(3'd4, 8'h05, "R7 overrun sticky");
    bus_wr(3'd4, 8'h01);
    expect_rd(3'd4, 8'h01, "R7 overrun cleared");

    // R8 mode change mid-byte applies to next byte
    bus_wr(3'd0, 8'hC3);
    model = ref_byte(model, 8'hC3, 1'b1);
    bus_wr(3'd4, 8'h00);
    settle();
    expect_acc("R8 in-flight byte kept CRC-32");

    // R11 CRC-16 leaves upper bytes alone
    keep = model;
    feed(8'h9E, 1'b0);
    feed(8'h01, 1'b0);
    expect_rd(3'd2, keep[23:16], "R11 upper byte 2");
    expect_rd(3'd3, keep[31:24], "R11 upper byte 3");
    expect_acc("R11 crc16 on top");

    // R9 writes to unused / read-only addresses
    for (int a = 2; a < 8; a++) begin
      if (a != 4) bus_wr(3'(a), 8'hFF);
    end
    expect_acc("R9 ignored writes");
    expect_rd(3'd4, 8'h00, "R9 status unchanged");

    // R6 clear aborts a byte in flight
    bus_wr(3'd0, 8'hE7);
    bus_wr(3'd1, 8'h00);
    model = 32'd0;
    expect_rd(3'd4, 8'h00, "R6 busy dropped");
    settle();
    expect_acc("R6 abort clear");
    feed(8'h80, 1'b0);
    expect_acc("R6 fresh after abort");

    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule